// File: doc/BRIEF.md
# Cascadable Dual Pulse-Width Generator

This block holds two programmable square-wave generators that share one clock divider. Each generator counts down a value for the low time of its output and then a second value for the high time, so software sets both the period and the duty cycle of the waveform. The pair can also be joined into a single generator with 16-bit low and high times, where the two 8-bit counters form one chain. Two copies of the block give four 8-bit outputs, or two 16-bit outputs.

Each channel has a run enable, an output gate for its pin, a count-clock select taken from taps of a free-running divider, and a flag that is raised at the end of every high phase. Reload values are loaded through per-channel write strobes. A value that is written mid-phase only takes effect at the next load, so the waveform never gets a cut-short phase.

Top module: `ppg_pair`

## Requirements
- R1: After reset both pins and both flags are 0 and all four reload bytes are 0, so a channel enabled with no writes gives a high phase of one tick and a low phase of one tick.
- R2: A divider counter of 4 bits is 0 after reset and increases by one every clock. A select value s in 0..4 gives a count tick in every cycle where the low s bits of that counter are all ones, which is a divide ratio of 2^s (1 to 16). Values 5 to 7 act as 4.
- R3: At the first tick after a channel is enabled, it loads its low value L and holds its level low. From then on the low phase lasts L+1 ticks and the high phase lasts H+1 ticks, and the two phases alternate.
- R4: While a channel's enable is 0, its pin is 0. When it is enabled again it restarts from the low phase, and its first rising edge comes L+2 clocks after the enable is sampled, at a divide ratio of 1.
- R5: A pulse on strobe bit c captures byte c of `low_val` and of `high_val` (bits 7:0 for channel 0, bits 15:8 for channel 1). A phase that is already running keeps its length, and the new values apply from the next load onward.
- R6: When `join_en` is 1, channel 0's enable and select control one 16-bit generator. Its low time is {low byte of channel 1, low byte of channel 0} and its high time is built the same way from the high bytes. Its waveform appears on both pins. Channel 1's enable and select are ignored. `join_en` is changed only while channel 0 is disabled.
- R7: A channel's flag goes to 1 at the end of each high phase and holds until a clear pulse on its `irq_clr` bit. A set in the same cycle as a clear wins.
- R8: Each pin is the channel's level ANDed with its `out_en` bit. Gating a pin off does not disturb the counting.
- R9: In split mode the two channels run independently, each at its own count rate and with its own reload values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| join_en | input | 1 | 1 joins both channels into one 16-bit generator |
| ch_en | input | 2 | Run enable per channel |
| out_en | input | 2 | Pin gate per channel |
| clk_sel0 | input | 3 | Count-clock select of channel 0 (ratio 2^s) |
| clk_sel1 | input | 3 | Count-clock select of channel 1 |
| rld_wr | input | 2 | Reload write strobe per channel |
| low_val | input | 16 | Low-time bytes, channel 0 in bits 7:0 |
| high_val | input | 16 | High-time bytes, channel 0 in bits 7:0 |
| irq_clr | input | 2 | Flag clear per channel |
| pin | output | 2 | Waveform outputs |
| irq | output | 2 | End-of-high-phase flags |

## Verification
Directed patterns measure phase lengths in clocks. The default zero reloads, a 3/5 split and the ratios 4 and 16 separate the L+1 and H+1 counting from the tick spacing. A write made during a high phase must leave that phase at its old length and change only the phases after it, which shows that loads happen only at phase ends. A joined setting of 0x0102/0x0100 can only give 259 and 257 clocks if the borrow passes correctly from the low byte to the high byte. Constrained random toggling of the enables, selects, gates, writes, clears and mode is then compared cycle by cycle against a reference model in the bench.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    // State of one phase sequencer
    typedef struct packed {
        logic run;   // channel has made its first load
        logic lvl;   // current waveform level
        logic irq;   // end-of-high flag
    } phase_t;

endpackage

// File: rtl/ppg_prescaler.sv
module ppg_prescaler #(
    parameter int NUM_TAPS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_TAPS-1:0] taps
);
    localparam int PW = NUM_TAPS - 1;

    logic [PW-1:0] p_d, p_q;

    always_comb begin
        p_d = p_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign taps[0] = 1'b1;
    for (genvar s = 1; s < NUM_TAPS; s++) begin : g_tap
        assign taps[s] = &p_q[s-1:0];
    end

    // R2: divider advances by one on every clock
    a_r2_divider_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> p_q == $past(p_q) + PW'(1));

endmodule

// File: rtl/ppg_slice.sv
module ppg_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)     cnt_d = load_val;
        else if (dec) cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R3: a load places the reload byte in the counter
    a_r3_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));

    // R3: a count step lowers the counter by exactly one
    a_r3_dec_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> cnt_q == $past(cnt_q) - W'(1));

endmodule

// File: rtl/ppg_phase.sv
module ppg_phase
    import ppg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic zero,
    input  logic irq_clr,
    output logic load,
    output logic use_high,
    output logic dec,
    output logic level,
    output logic irq
);
    phase_t st_d, st_q;
    logic   irq_set;

    always_comb begin
        st_d     = st_q;
        load     = 1'b0;
        use_high = 1'b0;
        dec      = 1'b0;
        irq_set  = 1'b0;
        if (!en) begin
            st_d.run = 1'b0;
            st_d.lvl = 1'b0;
        end else if (tick) begin
            if (!st_q.run) begin
                st_d.run = 1'b1;
                st_d.lvl = 1'b0;
                load     = 1'b1;
            end else if (zero) begin
                load     = 1'b1;
                use_high = !st_q.lvl;
                st_d.lvl = !st_q.lvl;
                irq_set  = st_q.lvl;
            end else begin
                dec = 1'b1;
            end
        end
        st_d.irq = irq_set | (st_q.irq & !irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;
    assign irq   = st_q.irq;

    // R4: a disabled channel drops to low
    a_r4_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !st_q.lvl);

    // R3: the level only moves on a count tick
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> st_q.lvl == $past(st_q.lvl));

    // R7: the flag rises only where a high phase ends
    a_r7_set_at_high_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> ($past(st_q.lvl) && !st_q.lvl));

    // R7: the flag holds until cleared
    a_r7_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !irq_clr) |=> st_q.irq);

endmodule

// File: rtl/ppg_pair.sv
module ppg_pair
    import ppg_pkg::*;
#(
    parameter int CW       = 8,
    parameter int NUM_TAPS = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        join_en,
    input  logic [1:0]                  ch_en,
    input  logic [1:0]                  out_en,
    input  logic [$clog2(NUM_TAPS)-1:0] clk_sel0,
    input  logic [$clog2(NUM_TAPS)-1:0] clk_sel1,
    input  logic [1:0]                  rld_wr,
    input  logic [2*CW-1:0]             low_val,
    input  logic [2*CW-1:0]             high_val,
    input  logic [1:0]                  irq_clr,
    output logic [1:0]                  pin,
    output logic [1:0]                  irq
);
    localparam int SEL_W = $clog2(NUM_TAPS);
    localparam int NCH   = 2;

    typedef struct packed {
        logic [NCH-1:0][CW-1:0] lo;
        logic [NCH-1:0][CW-1:0] hi;
    } reload_t;

    reload_t rld_d, rld_q;

    logic [NUM_TAPS-1:0]        taps;
    logic [NCH-1:0][SEL_W-1:0]  sel_in;
    logic [NCH-1:0]             tick, en_eff, zero_ch;
    logic [NCH-1:0]             load, use_high, dec, level;
    logic [NCH-1:0]             sl_load, sl_dec, sl_zero, sl_high;
    logic [NCH-1:0][CW-1:0]     sl_val;

    function automatic logic pick_tap(input logic [NUM_TAPS-1:0] t,
                                      input logic [SEL_W-1:0]    s);
        if (32'(s) >= NUM_TAPS) return t[NUM_TAPS-1];
        return t[s];
    endfunction

    // Reload bytes
    always_comb begin
        rld_d = rld_q;
        for (int c = 0; c < NCH; c++) begin
            if (rld_wr[c]) begin
                rld_d.lo[c] = low_val[c*CW +: CW];
                rld_d.hi[c] = high_val[c*CW +: CW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rld_q <= '0;
        else        rld_q <= rld_d;
    end

    ppg_prescaler #(.NUM_TAPS(NUM_TAPS)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps)
    );

    // Channel steering: in joined mode channel 0 drives both byte slices
    always_comb begin
        sel_in[0] = clk_sel0;
        sel_in[1] = clk_sel1;
        for (int c = 0; c < NCH; c++) tick[c] = pick_tap(taps, sel_in[c]);

        en_eff[0]  = ch_en[0];
        en_eff[1]  = ch_en[1] & !join_en;
        zero_ch[0] = join_en ? (&sl_zero) : sl_zero[0];
        zero_ch[1] = sl_zero[1];

        sl_load[0] = load[0];
        sl_dec[0]  = dec[0];
        sl_high[0] = use_high[0];
        sl_load[1] = join_en ? load[0]               : load[1];
        sl_dec[1]  = join_en ? (dec[0] & sl_zero[0]) : dec[1];
        sl_high[1] = join_en ? use_high[0]           : use_high[1];
        for (int c = 0; c < NCH; c++)
            sl_val[c] = sl_high[c] ? rld_q.hi[c] : rld_q.lo[c];

        pin[0] = level[0] & ch_en[0] & out_en[0];
        pin[1] = join_en ? (level[0] & ch_en[0] & out_en[1])
                         : (level[1] & ch_en[1] & out_en[1]);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ppg_phase u_phase (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick[c]),
            .en       (en_eff[c]),
            .zero     (zero_ch[c]),
            .irq_clr  (irq_clr[c]),
            .load     (load[c]),
            .use_high (use_high[c]),
            .dec      (dec[c]),
            .level    (level[c]),
            .irq      (irq[c])
        );

        ppg_slice #(.W(CW)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (sl_load[c]),
            .dec      (sl_dec[c]),
            .load_val (sl_val[c]),
            .zero     (sl_zero[c])
        );
    end

    // R6: in joined mode the upper sequencer stays idle and low
    a_r6_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
        join_en |=> !level[1]);

    // R5: a reload write changes only the addressed byte lane
    a_r5_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
        !rld_wr[1] |=> rld_q.lo[1] == $past(rld_q.lo[1]));

endmodule

// File: tb/ppg_pair_tb_top.sv
`timescale 1ns/1ps
module ppg_pair_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        join_en = 1'b0;
    logic [1:0]  ch_en = '0, out_en = '0, rld_wr = '0, irq_clr = '0;
    logic [2:0]  clk_sel0 = '0, clk_sel1 = '0;
    logic [15:0] low_val = '0, high_val = '0;
    logic [1:0]  pin, irq;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    ppg_pair dut_i (
        .clk(clk), .rst_n(rst_n), .join_en(join_en), .ch_en(ch_en),
        .out_en(out_en), .clk_sel0(clk_sel0), .clk_sel1(clk_sel1),
        .rld_wr(rld_wr), .low_val(low_val), .high_val(high_val),
        .irq_clr(irq_clr), .pin(pin), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [3:0]  m_pre;
    logic [1:0]  m_run, m_lvl, m_irq;
    logic [15:0] m_cnt [2];
    logic [7:0]  m_lo [2], m_hi [2];

    function automatic bit m_tick(input logic [3:0] pre, input int s);
        int s2 = (s > 4) ? 4 : s;
        int mask = (1 << s2) - 1;
        return (int'(pre) & mask) == mask;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre <= '0; m_run <= '0; m_lvl <= '0; m_irq <= '0;
            for (int c = 0; c < 2; c++) begin
                m_cnt[c] <= '0; m_lo[c] <= '0; m_hi[c] <= '0;
            end
        end else begin
            m_pre <= m_pre + 4'd1;
            for (int c = 0; c < 2; c++) begin
                if (rld_wr[c]) begin
                    m_lo[c] <= low_val[c*8 +: 8];
                    m_hi[c] <= high_val[c*8 +: 8];
                end
            end
            for (int c = 0; c < 2; c++) begin
                bit en, t, setf;
                logic [15:0] lv, hv;
                en = ch_en[c] && (c == 0 || !join_en);
                t  = m_tick(m_pre, (c == 0) ? int'(clk_sel0) : int'(clk_sel1));
                lv = (join_en && c == 0) ? {m_lo[1], m_lo[0]} : {8'h00, m_lo[c]};
                hv = (join_en && c == 0) ? {m_hi[1], m_hi[0]} : {8'h00, m_hi[c]};
                setf = 1'b0;
                if (!en) begin
                    m_run[c] <= 1'b0; m_lvl[c] <= 1'b0;
                end else if (t) begin
                    if (!m_run[c]) begin
                        m_run[c] <= 1'b1; m_lvl[c] <= 1'b0; m_cnt[c] <= lv;
                    end else if (m_cnt[c] == 16'd0) begin
                        m_lvl[c] <= !m_lvl[c];
                        m_cnt[c] <= m_lvl[c] ? lv : hv;
                        setf = m_lvl[c];
                    end else begin
                        m_cnt[c] <= m_cnt[c] - 16'd1;
                    end
                end
                m_irq[c] <= setf | (m_irq[c] & !irq_clr[c]);
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            logic mp0, mp1;
            mp0 = m_lvl[0] & ch_en[0] & out_en[0];
            mp1 = join_en ? (m_lvl[0] & ch_en[0] & out_en[1])
                          : (m_lvl[1] & ch_en[1] & out_en[1]);
            chk("R3 model pin0", int'(pin[0]), int'(mp0));
            chk("R6 model pin1", int'(pin[1]), int'(mp1));
            chk("R7 model irq0", int'(irq[0]), int'(m_irq[0]));
            chk("R7 model irq1", int'(irq[1]), int'(m_irq[1]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input int c, input logic [7:0] lo, input logic [7:0] hi);
        low_val[c*8 +: 8]  = lo;
        high_val[c*8 +: 8] = hi;
        rld_wr[c] = 1'b1;
        step();
        rld_wr[c] = 1'b0;
    endtask

    task automatic wait_for(input int c, input logic v);
        for (int i = 0; i < 3000; i++) begin
            if (pin[c] == v) break;
            step();
        end
    endtask

    task automatic count_run(input int c, input logic v, output int n);
        n = 0;
        while (pin[c] == v && n < 3000) begin
            n++;
            step();
        end
    endtask

    task automatic high_len(input int c, output int n);
        wait_for(c, 1'b0);
        wait_for(c, 1'b1);
        count_run(c, 1'b1, n);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240607));
        repeat (3) step();
        rst_n = 1'b1;
        cmp_on = 1'b1;
        step();

        // R1: reset state
        chk("R1 pins after reset", int'(pin), 0);
        chk("R1 flags after reset", int'(irq), 0);

        // R1: zero reloads give one-tick phases
        out_en = 2'b11;
        ch_en[0] = 1'b1;
        high_len(0, n);
        chk("R1 default high length", n, 1);

        // R3: split channel 0 with L=3, H=5
        wr(0, 8'd3, 8'd5);
        high_len(0, n);
        chk("R3 high length", n, 6);
        count_run(0, 1'b0, n);
        chk("R3 low length", n, 4);

        // R2: divide by 4, then select 7 acts as 16
        clk_sel0 = 3'd2;
        high_len(0, n);
        chk("R2 high length ratio 4", n, 24);
        count_run(0, 1'b0, n);
        chk("R2 low length ratio 4", n, 16);
        clk_sel0 = 3'd7;
        high_len(0, n);
        chk("R2 high length select 7", n, 96);
        clk_sel0 = 3'd0;

        // R5: write during a high phase
        wait_for(0, 1'b0);
        wait_for(0, 1'b1);
        low_val[7:0] = 8'd1;
        high_val[7:0] = 8'd9;
        rld_wr[0] = 1'b1;
        count_run(0, 1'b1, n);
        chk("R5 running high phase unchanged", n, 6);
        count_run(0, 1'b0, n);
        chk("R5 next low uses new value", n, 2);
        count_run(0, 1'b1, n);
        chk("R5 next high uses new value", n, 10);
        rld_wr[0] = 1'b0;

        // R7: clear, set at high end, set wins over clear
        wait_for(0, 1'b1);
        irq_clr[0] = 1'b1;
        step();
        irq_clr[0] = 1'b0;
        chk("R7 flag cleared", int'(irq[0]), 0);
        wait_for(0, 1'b0);
        chk("R7 flag set at high end", int'(irq[0]), 1);
        irq_clr[0] = 1'b1;
        step();
        wait_for(0, 1'b1);
        chk("R7 flag held clear", int'(irq[0]), 0);
        wait_for(0, 1'b0);
        chk("R7 set wins over clear", int'(irq[0]), 1);
        step();
        chk("R7 clear after set", int'(irq[0]), 0);
        irq_clr[0] = 1'b0;

        // R8: gate off pin while counting continues
        out_en[0] = 1'b0;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            if (pin[0]) n++;
            step();
        end
        chk("R8 gated pin stays low", n, 0);
        out_en[0] = 1'b1;

        // R4: disable, then re-enable timing (L=1, ratio 1)
        ch_en[0] = 1'b0;
        step();
        chk("R4 pin low when disabled", int'(pin[0]), 0);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            if (pin[0]) n++;
            step();
        end
        chk("R4 stays low while disabled", n, 0);
        ch_en[0] = 1'b1;
        n = 0;
        do begin
            step();
            n++;
        end while (!pin[0] && n < 100);
        chk("R4 first rise after enable", n, 3);

        // R9: independent split channels
        wr(0, 8'd0, 8'd0);
        wr(1, 8'd2, 8'd2);
        clk_sel1 = 3'd1;
        ch_en[1] = 1'b1;
        high_len(1, n);
        chk("R9 channel 1 high length", n, 6);
        count_run(1, 1'b0, n);
        chk("R9 channel 1 low length", n, 6);
        high_len(0, n);
        chk("R9 channel 0 high length", n, 1);

        // R6: joined 16-bit generator
        ch_en[0] = 1'b0;
        step();
        join_en = 1'b1;
        step();
        wr(0, 8'h02, 8'h00);
        wr(1, 8'h01, 8'h01);
        ch_en[0] = 1'b1;
        high_len(0, n);
        chk("R6 joined high length", n, 257);
        count_run(0, 1'b0, n);
        chk("R6 joined low length", n, 259);
        n = 0;
        for (int i = 0; i < 600; i++) begin
            if (i == 300) ch_en[1] = ~ch_en[1];
            if (pin[1] != pin[0]) n++;
            step();
        end
        chk("R6 both pins follow joined wave", n, 0);
        ch_en[0] = 1'b0;
        step();
        join_en = 1'b0;
        step();

        // Constrained random run against the model (R2 R3 R5 R6 R7 R8 R9)
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 100);
            irq_clr = '0;
            if (r < 3)       ch_en[1] = ~ch_en[1];
            else if (r < 6)  ch_en[0] = ~ch_en[0];
            else if (r < 10) begin
                clk_sel0 = 3'($urandom % 8);
                clk_sel1 = 3'($urandom % 8);
            end else if (r < 16) begin
                int c = int'($urandom % 2);
                low_val[c*8 +: 8]  = 8'($urandom % 6);
                high_val[c*8 +: 8] = 8'($urandom % 6);
                rld_wr[c] = 1'b1;
            end else if (r < 20) out_en = 2'($urandom % 4);
            else if (r < 24) irq_clr = 2'($urandom % 4);
            else if (r == 99) begin
                ch_en[0] = 1'b0;
                step();
                join_en = ~join_en;
            end
            step();
            rld_wr = '0;
        end

        cmp_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule